// File: doc/BRIEF.md
# Super I/O Style Configuration Port

This block is a configuration register file reached through a two-byte I/O window. Offset 0 is the index port, which names a register. Offset 1 is the data port, which reads or writes the register that the index names. After reset the window is locked. Software opens it by writing an unlock key byte to the index port twice in a row, and closes it again with an exit byte. While the window is open it shows global identification registers and a device selector. The selector picks one of several per-device register banks. Each bank holds the I/O base address, the interrupt mode, the FIFO control and the half-duplex line control for one serial channel.

The per-device fields leave the block as plain output vectors so that neighbouring serial cores can use them directly. Decoding the window's base address on the host bus is done outside this block, which sees only a one-bit offset and a write strobe. Read data is combinational from the offset and the current state.

A three-state machine controls access. In `ST_LOCKED` the window is closed. An index write of the key moves it to `ST_KEY_SEEN`. A second index write of the key moves it to `ST_OPEN`, and any other index write from `ST_KEY_SEEN` falls back to `ST_LOCKED`. In `ST_OPEN` an index write of 0xAA returns to `ST_LOCKED`, and every other index write loads the index register. Data-port traffic never moves the state.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked and both offsets read 0xFF. The device selector is 0. The bank base addresses are 0x3F8, 0x2F8, 0x3E8 and 0x2E8 for banks 0 to 3, and every other per-device field is 0.
- R2: Two consecutive index-port writes of the key (default 0x87) open the window. `cfg_unlocked` rises in the cycle after the second write.
- R3: When the first key write is followed by any other index-port write, the state returns to locked, and two fresh key writes are needed to open the window.
- R4: While open, an index-port write of 0xAA locks the window in the next cycle.
- R5: While locked, reads at either offset return 0xFF and data-port writes change no register.
- R6: While open, register 0x20 reads 0x02 and 0x21 reads 0x16 (chip ID 0x1602, low byte first). Register 0x23 reads 0x19 and 0x24 reads 0x34, for any selector value. Register 0x07 reads and writes the device selector.
- R7: Registers 0x60 (high byte) and 0x61 (low byte) hold the 16-bit I/O base of the bank named by the selector. A write reaches only that bank.
- R8: Register 0x70 holds the interrupt-share enable in bit 4 and the interrupt mode in bits 6:5 (00 level/active low, 01 edge/active high). Its other bits read 0.
- R9: Register 0xF6 holds the FIFO mode in bits 1:0 (11 = 128 bytes) and the receive threshold mode in bits 5:4 (10 = 4x). Its other bits read 0.
- R10: Register 0xF0 holds RTS invert in bit 5, auto-direction enable in bit 4, the receive-side wait in bit 3 and the transmit-side wait in bit 2. Its other bits read 0.
- R11: With a selector of 4 or more, bank registers read 0xFF and bank writes change no bank.
- R12: While open, the index port reads back the current index, and an unassigned register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Write strobe for the window |
| io_addr | input | 1 | Window offset: 0 index port, 1 data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data at the offset given by io_addr |
| cfg_unlocked | output | 1 | High while the window is open |
| dev_iobase | output | 16*NDEV | I/O base per bank, bank 0 in the low bits |
| dev_irq_share | output | NDEV | Interrupt-share enable per bank |
| dev_irq_mode | output | 2*NDEV | Interrupt mode per bank |
| dev_fifo_mode | output | 2*NDEV | FIFO size mode per bank |
| dev_rx_thr | output | 2*NDEV | Receive threshold mode per bank |
| dev_rts_inv | output | NDEV | RTS invert per bank |
| dev_auto_dir | output | NDEV | Half-duplex auto-direction enable per bank |
| dev_rx_wait | output | NDEV | Receive-side wait delay enable per bank |
| dev_tx_wait | output | NDEV | Transmit-side wait delay enable per bank |

## Verification
The hardest state to reach is a broken unlock. The first key write has been accepted, but the write that follows it is something else, and the block must then lock rather than open on the next key. The stimulus writes the key, then a non-key index value, then a single key, and confirms the window is still locked before sending two fresh keys. A second hard-to-reach case is a selector beyond the last bank. The stimulus sets that selector while the window is open, writes every bank register, and then reads back all four real banks to show that none changed.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_SEEN = 2'd1,
        ST_OPEN     = 2'd2
    } lock_state_t;

    localparam logic [7:0] EXIT_CODE   = 8'hAA;
    localparam logic [7:0] REG_SELECT  = 8'h07;
    localparam logic [7:0] REG_CHIP_LO = 8'h20;
    localparam logic [7:0] REG_CHIP_HI = 8'h21;
    localparam logic [7:0] REG_VEND_A  = 8'h23;
    localparam logic [7:0] REG_VEND_B  = 8'h24;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
    localparam logic [7:0] REG_IRQ     = 8'h70;
    localparam logic [7:0] REG_LINE    = 8'hF0;
    localparam logic [7:0] REG_FIFO    = 8'hF6;

    localparam logic [7:0] VEND_A_VAL  = 8'h19;
    localparam logic [7:0] VEND_B_VAL  = 8'h34;

    function automatic logic [15:0] default_base(input int idx);
        case (idx % 4)
            0:       return 16'h03F8;
            1:       return 16'h02F8;
            2:       return 16'h03E8;
            default: return 16'h02E8;
        endcase
    endfunction

    function automatic logic is_bank_reg(input logic [7:0] a);
        return (a == REG_BASE_HI) || (a == REG_BASE_LO) || (a == REG_IRQ) ||
               (a == REG_LINE) || (a == REG_FIFO);
    endfunction

endpackage

// File: rtl/sio_lock_fsm.sv
module sio_lock_fsm
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = 8'h87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index
);

    lock_state_t state_q, state_d;
    logic        load_index;

    // state register and index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            index   <= 8'h00;
        end else begin
            state_q <= state_d;
            if (load_index) index <= wdata;
        end
    end

    // next state and index load
    always_comb begin
        state_d    = state_q;
        load_index = 1'b0;
        if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED:   if (wdata == UNLOCK_KEY) state_d = ST_KEY_SEEN;
                ST_KEY_SEEN: state_d = (wdata == UNLOCK_KEY) ? ST_OPEN : ST_LOCKED;
                ST_OPEN: begin
                    if (wdata == EXIT_CODE) state_d = ST_LOCKED;
                    else                    load_index = 1'b1;
                end
                default:     state_d = ST_LOCKED;
            endcase
        end
    end

    assign unlocked = (state_q == ST_OPEN);

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] RESET_BASE = 16'h03F8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [15:0] iobase,
    output logic        irq_share,
    output logic [1:0]  irq_mode,
    output logic [1:0]  fifo_mode,
    output logic [1:0]  rx_thr,
    output logic [3:0]  line_ctl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iobase    <= RESET_BASE;
            irq_share <= 1'b0;
            irq_mode  <= 2'b00;
            fifo_mode <= 2'b00;
            rx_thr    <= 2'b00;
            line_ctl  <= 4'h0;
        end else if (we) begin
            case (addr)
                REG_BASE_HI: iobase[15:8] <= wdata;
                REG_BASE_LO: iobase[7:0]  <= wdata;
                REG_IRQ: begin
                    irq_share <= wdata[4];
                    irq_mode  <= wdata[6:5];
                end
                REG_FIFO: begin
                    fifo_mode <= wdata[1:0];
                    rx_thr    <= wdata[5:4];
                end
                REG_LINE: line_ctl <= wdata[5:2];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            REG_BASE_HI: rdata = iobase[15:8];
            REG_BASE_LO: rdata = iobase[7:0];
            REG_IRQ:     rdata = {1'b0, irq_mode, irq_share, 4'h0};
            REG_FIFO:    rdata = {2'b00, rx_thr, 2'b00, fifo_mode};
            REG_LINE:    rdata = {2'b00, line_ctl, 2'b00};
            default:     rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          NDEV       = 4,
    parameter logic [7:0]  UNLOCK_KEY = 8'h87,
    parameter logic [15:0] CHIP_ID    = 16'h1602
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_unlocked,
    output logic [16*NDEV-1:0] dev_iobase,
    output logic [NDEV-1:0]   dev_irq_share,
    output logic [2*NDEV-1:0] dev_irq_mode,
    output logic [2*NDEV-1:0] dev_fifo_mode,
    output logic [2*NDEV-1:0] dev_rx_thr,
    output logic [NDEV-1:0]   dev_rts_inv,
    output logic [NDEV-1:0]   dev_auto_dir,
    output logic [NDEV-1:0]   dev_rx_wait,
    output logic [NDEV-1:0]   dev_tx_wait
);

    localparam int         SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam logic [7:0] NDEV_B = 8'(NDEV);

    logic [7:0] index;
    logic [7:0] ldn_q;
    logic       data_wr;
    logic       ldn_ok;
    logic [7:0] bank_rd [NDEV];

    sio_lock_fsm #(.UNLOCK_KEY(UNLOCK_KEY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && !io_addr),
        .wdata    (io_wdata),
        .unlocked (cfg_unlocked),
        .index    (index)
    );

    assign data_wr = io_wr && io_addr && cfg_unlocked;
    assign ldn_ok  = (ldn_q < NDEV_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                ldn_q <= 8'h00;
        else if (data_wr && index == REG_SELECT)   ldn_q <= io_wdata;
    end

    for (genvar i = 0; i < NDEV; i++) begin : g_bank
        logic [3:0] line;
        sio_dev_bank #(.RESET_BASE(default_base(i))) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (data_wr && ldn_ok && (ldn_q[SEL_W-1:0] == SEL_W'(i))),
            .addr      (index),
            .wdata     (io_wdata),
            .rdata     (bank_rd[i]),
            .iobase    (dev_iobase[16*i +: 16]),
            .irq_share (dev_irq_share[i]),
            .irq_mode  (dev_irq_mode[2*i +: 2]),
            .fifo_mode (dev_fifo_mode[2*i +: 2]),
            .rx_thr    (dev_rx_thr[2*i +: 2]),
            .line_ctl  (line)
        );
        assign dev_rts_inv[i]  = line[3];
        assign dev_auto_dir[i] = line[2];
        assign dev_rx_wait[i]  = line[1];
        assign dev_tx_wait[i]  = line[0];
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (cfg_unlocked) begin
            if (!io_addr) begin
                io_rdata = index;
            end else if (is_bank_reg(index)) begin
                io_rdata = ldn_ok ? bank_rd[ldn_q[SEL_W-1:0]] : 8'hFF;
            end else begin
                case (index)
                    REG_SELECT:  io_rdata = ldn_q;
                    REG_CHIP_LO: io_rdata = CHIP_ID[7:0];
                    REG_CHIP_HI: io_rdata = CHIP_ID[15:8];
                    REG_VEND_A:  io_rdata = VEND_A_VAL;
                    REG_VEND_B:  io_rdata = VEND_B_VAL;
                    default:     io_rdata = 8'h00;
                endcase
            end
        end
    end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int         NDEV       = 4,
    parameter logic [7:0] UNLOCK_KEY = 8'h87
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_unlocked,
    input logic [16*NDEV-1:0] dev_iobase,
    input logic [2*NDEV-1:0] dev_irq_mode,
    input logic [2*NDEV-1:0] dev_fifo_mode,
    input logic [7:0]        ldn_q
);

    localparam logic [7:0] NDEV_B = 8'(NDEV);

    // R5
    locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |-> io_rdata == 8'hFF);

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(io_wr && !io_addr && io_wdata == UNLOCK_KEY));

    // R4
    exit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_wr && !io_addr && io_wdata == 8'hAA) |=> !cfg_unlocked);

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> ($stable(dev_iobase) && $stable(dev_irq_mode) && $stable(dev_fifo_mode)));

    // R11
    bad_select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ldn_q >= NDEV_B) |=> ($stable(dev_iobase) && $stable(dev_irq_mode) && $stable(dev_fifo_mode)));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NDEV(NDEV), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr         (io_wr),
    .io_addr       (io_addr),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .cfg_unlocked  (cfg_unlocked),
    .dev_iobase    (dev_iobase),
    .dev_irq_mode  (dev_irq_mode),
    .dev_fifo_mode (dev_fifo_mode),
    .ldn_q         (ldn_q)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

    localparam int ND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_wr = 1'b0;
    logic io_addr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic cfg_unlocked;
    logic [16*ND-1:0] dev_iobase;
    logic [ND-1:0] dev_irq_share, dev_rts_inv, dev_auto_dir, dev_rx_wait, dev_tx_wait;
    logic [2*ND-1:0] dev_irq_mode, dev_fifo_mode, dev_rx_thr;

    always #4 clk = ~clk;

    sio_cfg_port u_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
        .dev_iobase(dev_iobase), .dev_irq_share(dev_irq_share),
        .dev_irq_mode(dev_irq_mode), .dev_fifo_mode(dev_fifo_mode),
        .dev_rx_thr(dev_rx_thr), .dev_rts_inv(dev_rts_inv),
        .dev_auto_dir(dev_auto_dir), .dev_rx_wait(dev_rx_wait),
        .dev_tx_wait(dev_tx_wait)
    );

    int checks = 0;
    int fails = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // behavioural reference model
    int m_state;            // 0 locked, 1 one key seen, 2 open
    int m_idx, m_ldn;
    int m_base[ND];
    int m_irq[ND];
    int m_line[ND];
    int m_fifo[ND];

    task automatic model_reset();
        m_state = 0; m_idx = 0; m_ldn = 0;
        m_base[0] = 'h3F8; m_base[1] = 'h2F8; m_base[2] = 'h3E8; m_base[3] = 'h2E8;
        for (int i = 0; i < ND; i++) begin
            m_irq[i] = 0; m_line[i] = 0; m_fifo[i] = 0;
        end
    endtask

    task automatic model_write(input int a, input int d);
        if (a == 0) begin
            if (m_state == 2) begin
                if (d == 'hAA) m_state = 0; else m_idx = d;
            end else if (m_state == 1) begin
                m_state = (d == 'h87) ? 2 : 0;
            end else if (d == 'h87) begin
                m_state = 1;
            end
        end else if (m_state == 2) begin
            if (m_idx == 'h07) m_ldn = d;
            else if (m_ldn < ND) begin
                case (m_idx)
                    'h60: m_base[m_ldn] = (m_base[m_ldn] & 'hFF) | (d << 8);
                    'h61: m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | d;
                    'h70: m_irq[m_ldn]  = d & 'h70;
                    'hF0: m_line[m_ldn] = d & 'h3C;
                    'hF6: m_fifo[m_ldn] = d & 'h33;
                    default: ;
                endcase
            end
        end
    endtask

    function automatic int model_read(input int a);
        if (m_state != 2) return 'hFF;
        if (a == 0) return m_idx;
        case (m_idx)
            'h07: return m_ldn;
            'h20: return 'h02;
            'h21: return 'h16;
            'h23: return 'h19;
            'h24: return 'h34;
            'h60: return (m_ldn < ND) ? (m_base[m_ldn] >> 8) : 'hFF;
            'h61: return (m_ldn < ND) ? (m_base[m_ldn] & 'hFF) : 'hFF;
            'h70: return (m_ldn < ND) ? m_irq[m_ldn] : 'hFF;
            'hF0: return (m_ldn < ND) ? m_line[m_ldn] : 'hFF;
            'hF6: return (m_ldn < ND) ? m_fifo[m_ldn] : 'hFF;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison of every output field against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R2 unlocked flag", int'(cfg_unlocked), (m_state == 2) ? 1 : 0);
            for (int i = 0; i < ND; i++) begin
                check("R7 io base", int'(dev_iobase[16*i +: 16]), m_base[i]);
                check("R8 irq share", int'(dev_irq_share[i]), (m_irq[i] >> 4) & 1);
                check("R8 irq mode", int'(dev_irq_mode[2*i +: 2]), (m_irq[i] >> 5) & 3);
                check("R9 fifo mode", int'(dev_fifo_mode[2*i +: 2]), m_fifo[i] & 3);
                check("R9 rx threshold", int'(dev_rx_thr[2*i +: 2]), (m_fifo[i] >> 4) & 3);
                check("R10 rts invert", int'(dev_rts_inv[i]), (m_line[i] >> 5) & 1);
                check("R10 auto dir", int'(dev_auto_dir[i]), (m_line[i] >> 4) & 1);
                check("R10 rx wait", int'(dev_rx_wait[i]), (m_line[i] >> 3) & 1);
                check("R10 tx wait", int'(dev_tx_wait[i]), (m_line[i] >> 2) & 1);
            end
        end
    end

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk);
        model_write(int'(a), int'(d));
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input bit a, input string req);
        @(negedge clk);
        io_wr = 1'b0; io_addr = a;
        #1;
        check(req, int'(io_rdata), model_read(int'(a)));
    endtask

    task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
        wr(1'b0, r); wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] r, input string req);
        wr(1'b0, r); rd(1'b1, req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1 reset state
        rd(1'b0, "R1 index port after reset");
        rd(1'b1, "R1 data port after reset");
        check("R1 bank2 base", int'(dev_iobase[47:32]), 'h3E8);

        // R5 locked: writes ignored, reads 0xFF
        wr(1'b1, 8'h55);
        rd(1'b1, "R5 locked data read");
        // R3 broken key sequence
        wr(1'b0, 8'h87);
        wr(1'b0, 8'h12);
        wr(1'b0, 8'h87);
        check("R3 still locked after broken sequence", int'(cfg_unlocked), 0);
        wr(1'b0, 8'h12);
        // R2 proper unlock
        wr(1'b0, 8'h87);
        wr(1'b0, 8'h87);
        check("R2 open after two keys", int'(cfg_unlocked), 1);

        // R12 index readback and unassigned register
        wr(1'b0, 8'h55);
        rd(1'b0, "R12 index readback");
        rd(1'b1, "R12 unassigned reads zero");

        // R6 identification
        reg_rd(8'h20, "R6 chip id low");
        reg_rd(8'h21, "R6 chip id high");
        reg_rd(8'h23, "R6 vendor byte a");
        reg_rd(8'h24, "R6 vendor byte b");

        // R7..R10 each bank with distinct patterns
        for (int b = 0; b < ND; b++) begin
            reg_wr(8'h07, 8'(b));
            reg_rd(8'h07, "R6 selector readback");
            reg_wr(8'h60, 8'(8'h10 + b));
            reg_wr(8'h61, 8'(8'h80 + 8 * b));
            reg_wr(8'h70, (b % 2 == 0) ? 8'hFF : 8'h30);
            reg_wr(8'hF6, (b % 2 == 0) ? 8'h23 : 8'hFF);
            reg_wr(8'hF0, (b < 2) ? 8'hFF : 8'h14);
            reg_rd(8'h60, "R7 base high");
            reg_rd(8'h61, "R7 base low");
            reg_rd(8'h70, "R8 irq register");
            reg_rd(8'hF6, "R9 fifo register");
            reg_rd(8'hF0, "R10 line register");
        end

        // R11 out-of-range selector
        reg_wr(8'h07, 8'h04);
        reg_wr(8'h60, 8'hAB);
        reg_wr(8'h61, 8'hCD);
        reg_wr(8'h70, 8'h00);
        reg_wr(8'hF6, 8'h00);
        reg_wr(8'hF0, 8'h00);
        reg_rd(8'h61, "R11 bank read with bad selector");
        reg_rd(8'h24, "R6 vendor with bad selector");
        for (int b = 0; b < ND; b++) begin
            reg_wr(8'h07, 8'(b));
            reg_rd(8'h61, "R11 bank unchanged");
            reg_rd(8'h70, "R11 bank irq unchanged");
        end

        // R4 exit, then R5 locked writes ignored
        reg_wr(8'h07, 8'h01);
        wr(1'b0, 8'h61);
        wr(1'b0, 8'hAA);
        check("R4 locked after exit", int'(cfg_unlocked), 0);
        wr(1'b1, 8'h00);
        rd(1'b0, "R5 locked index read");
        rd(1'b1, "R5 locked data read");
        wr(1'b0, 8'h87);
        wr(1'b0, 8'h87);
        reg_rd(8'h61, "R5 register kept while locked");
        reg_rd(8'h07, "R5 selector kept while locked");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule